// File: doc/BRIEF.md
# Interleaved Memory Channel Address Decoder

This block turns a physical system address into a target index and a compacted address local to that target. The target index is two bits: the upper bit picks one of two memory slices and the lower bit picks one of two channels inside that slice. Each active interleave dimension takes its target bit either from an XOR reduction of selected address bits or, inside a configurable power-of-two override window, from a fixed address bit. The bits used for interleaving are then squeezed out of the address, and the hole between the top of low memory and 4 GB is closed, so that every channel sees a dense address space.

Configuration arrives on static input ports that are set once and left unchanged while addresses flow. Addresses enter through a valid/ready handshake and each accepted address yields exactly one registered result one cycle later. Addresses that are not DRAM are flagged as errors rather than decoded.

Top module: `chan_addr_decoder`

## Requirements
- R1: An address with bit 39 set, an address in [top of low memory, 4 GB), or an address at or above top of high memory gives `out_err`=1 with `out_target`=0 and `out_addr`=0.
- R2: The contiguous address equals the input below 4 GB and the input minus (4 GB − top of low memory) from 4 GB up; with no interleave active, `out_addr` is that contiguous address and `out_target` is 0.
- R3: Slice interleave is active only when neither slice is switched off and both per-slice channel masks are nonzero; channel interleave is active only when channel 1 is on, dual-data mode is off and at least one per-slice mask is 2'b11. An inactive dimension drives its target bit to 0 and removes no address bit.
- R4: Interleave mode 0, 1, 2, 3 puts the selector on address bit 10, 11, 12, 12; when both dimensions are active the channel selector sits one bit above the slice selector.
- R5: In coarse mode the slice selector is bit 29 and the channel selector is bit 30 when both dimensions are active, or bit 29 when channel alone is active; the hash mask fields are then ignored.
- R6: A target bit is the XOR of the address bits picked by its hash mask; mask field bit i stands for address bit i+6; the slice hashes the raw address and the channel hashes the contiguous address; a selector bit joins its own mask only when the other dimension is inactive.
- R7: Inside a valid override window the slice bit is address bit 12, and the channel bit is address bit 13 with two slices active or bit 12 otherwise; those bits are the ones removed.
- R8: The window is valid only when enabled, its mask is nonzero and contiguous from its lowest set bit up through bit 39, and the base has no bit outside the mask; it covers base through base | ~mask. An invalid window has no effect.
- R9: Removing a bit keeps the bits below it and shifts those above it down by one; the channel bit is removed before the slice bit.
- R10: `in_ready` is high when the output is empty or being taken; each accepted address produces one `out_valid` result on the next cycle, held stable while `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tolm | input | 40 | Top of low memory (byte address) |
| cfg_tohm | input | 40 | Top of high memory (byte address) |
| cfg_slice0_off | input | 1 | Slice 0 switched off |
| cfg_slice1_off | input | 1 | Slice 1 switched off |
| cfg_ch1_off | input | 1 | Channel 1 switched off |
| cfg_dual_data | input | 1 | Dual-data mode (channel 1 unusable) |
| cfg_s0_chmask | input | 2 | Slice 0 symmetric channel mask |
| cfg_s1_chmask | input | 2 | Slice 1 symmetric channel mask |
| cfg_ilv_mode | input | 2 | Interleave granularity mode |
| cfg_coarse | input | 1 | Coarse (high-granularity) mode |
| cfg_slice_hfield | input | 26 | Slice hash mask field (bit i = address bit i+6) |
| cfg_chan_hfield | input | 26 | Channel hash mask field (bit i = address bit i+6) |
| cfg_win_en | input | 1 | Override window enable |
| cfg_win_base | input | 40 | Override window base |
| cfg_win_mask | input | 40 | Override window mask |
| in_valid | input | 1 | Input address valid |
| in_ready | output | 1 | Input address accepted when high with in_valid |
| in_addr | input | 40 | System address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_target | output | 2 | Target index {slice, channel} |
| out_addr | output | 40 | Compacted per-channel address |
| out_err | output | 1 | Address is not DRAM |

## Verification
The bench builds the decoder with its default parameters: a 40-bit address, a 26-bit hash field starting at bit 6, selectors based at bit 10 and the coarse selector at bit 29. These put the 4 GB hole, the bit-39 limit, all four interleave modes, coarse mode and a 256 MB override window above 4 GB within reach of short directed addresses, with hand-computed results at each boundary and a behavioural model from the requirements for randomized addresses under each configuration.

// File: rtl/cad_pkg.sv
package cad_pkg;
  // Interleave bit selector: en=0 means the dimension removes nothing.
  typedef struct packed {
    logic       en;
    logic [5:0] pos;
  } sel_t;
endpackage

// File: rtl/cad_cfg.sv
module cad_cfg import cad_pkg::*; #(
  parameter int ADDR_W     = 40,
  parameter int HM_W       = 26,
  parameter int HASH_LSB   = 6,
  parameter int SEL_BASE   = 10,
  parameter int COARSE_BIT = 29
) (
  input  logic              slice0_off,
  input  logic              slice1_off,
  input  logic              ch1_off,
  input  logic              dual_data,
  input  logic [1:0]        s0_chmask,
  input  logic [1:0]        s1_chmask,
  input  logic [1:0]        ilv_mode,
  input  logic              coarse,
  input  logic [HM_W-1:0]   slice_hfield,
  input  logic [HM_W-1:0]   chan_hfield,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_mask,
  output logic              two_slices,
  output logic              two_chans,
  output sel_t              slice_sel,
  output sel_t              chan_sel,
  output logic [ADDR_W-1:0] slice_hmask,
  output logic [ADDR_W-1:0] chan_hmask,
  output logic              win_ok,
  output logic [ADDR_W-1:0] win_lim
);
  localparam int PAD_W = ADDR_W - HM_W;

  logic [5:0]        base_pos;
  logic [ADDR_W-1:0] s_field, c_field, win_low;

  always_comb begin
    two_slices = !slice0_off && !slice1_off && (|s0_chmask) && (|s1_chmask);
    two_chans  = !ch1_off && !dual_data && ((&s0_chmask) || (&s1_chmask));

    base_pos = 6'(SEL_BASE) + ((ilv_mode == 2'd3) ? 6'd2 : {4'd0, ilv_mode});

    slice_sel.en  = two_slices;
    slice_sel.pos = coarse ? 6'(COARSE_BIT) : base_pos;

    chan_sel.en = two_chans;
    if (coarse) chan_sel.pos = two_slices ? 6'(COARSE_BIT + 1) : 6'(COARSE_BIT);
    else        chan_sel.pos = two_slices ? base_pos + 6'd1 : base_pos;

    s_field = coarse ? '0 : ({{PAD_W{1'b0}}, slice_hfield} << HASH_LSB);
    c_field = coarse ? '0 : ({{PAD_W{1'b0}}, chan_hfield} << HASH_LSB);

    slice_hmask = '0;
    if (two_slices)
      slice_hmask = s_field | (two_chans ? '0 : (ADDR_W'(1) << slice_sel.pos));
    chan_hmask = '0;
    if (two_chans)
      chan_hmask = c_field | (two_slices ? '0 : (ADDR_W'(1) << chan_sel.pos));

    // Lowest set bit of the mask; the mask must fill everything above it.
    win_low = win_mask & (~win_mask + ADDR_W'(1));
    win_ok  = win_en && (|win_mask) && (win_mask == ~(win_low - ADDR_W'(1)))
              && ((win_base & ~win_mask) == '0);
    win_lim = win_base | ~win_mask;
  end
endmodule

// File: rtl/cad_xor_hash.sv
module cad_xor_hash #(
  parameter int W = 40
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] mask,
  output logic         bit_o
);
  assign bit_o = ^(addr & mask);
endmodule

// File: rtl/cad_squeeze.sv
module cad_squeeze import cad_pkg::*; #(
  parameter int W = 40
) (
  input  logic [W-1:0] din,
  input  sel_t         sel,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic upper;
    if (i == W - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = din[i+1];
    end
    assign dout[i] = (sel.en && (6'(i) >= sel.pos)) ? upper : din[i];
  end
endmodule

// File: rtl/chan_addr_decoder.sv
module chan_addr_decoder import cad_pkg::*; #(
  parameter int ADDR_W     = 40,
  parameter int HM_W       = 26,
  parameter int HASH_LSB   = 6,
  parameter int SEL_BASE   = 10,
  parameter int COARSE_BIT = 29,
  parameter int WIN_LO_BIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_tolm,
  input  logic [ADDR_W-1:0] cfg_tohm,
  input  logic              cfg_slice0_off,
  input  logic              cfg_slice1_off,
  input  logic              cfg_ch1_off,
  input  logic              cfg_dual_data,
  input  logic [1:0]        cfg_s0_chmask,
  input  logic [1:0]        cfg_s1_chmask,
  input  logic [1:0]        cfg_ilv_mode,
  input  logic              cfg_coarse,
  input  logic [HM_W-1:0]   cfg_slice_hfield,
  input  logic [HM_W-1:0]   cfg_chan_hfield,
  input  logic              cfg_win_en,
  input  logic [ADDR_W-1:0] cfg_win_base,
  input  logic [ADDR_W-1:0] cfg_win_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_target,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);
  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);
  localparam int WIN_HI_BIT = WIN_LO_BIT + 1;

  logic              two_slices, two_chans, win_ok;
  sel_t              slice_sel, chan_sel, slice_rm, chan_rm;
  logic [ADDR_W-1:0] slice_hmask, chan_hmask, win_lim;
  logic [ADDR_W-1:0] contig, sq_chan, sq_both;
  logic              slice_hash, chan_hash, win_hit, is_err;
  logic              slice_bit, chan_bit;
  logic [5:0]        win_chan_pos;

  cad_cfg #(
    .ADDR_W(ADDR_W), .HM_W(HM_W), .HASH_LSB(HASH_LSB),
    .SEL_BASE(SEL_BASE), .COARSE_BIT(COARSE_BIT)
  ) u_cfg (
    .slice0_off(cfg_slice0_off), .slice1_off(cfg_slice1_off),
    .ch1_off(cfg_ch1_off), .dual_data(cfg_dual_data),
    .s0_chmask(cfg_s0_chmask), .s1_chmask(cfg_s1_chmask),
    .ilv_mode(cfg_ilv_mode), .coarse(cfg_coarse),
    .slice_hfield(cfg_slice_hfield), .chan_hfield(cfg_chan_hfield),
    .win_en(cfg_win_en), .win_base(cfg_win_base), .win_mask(cfg_win_mask),
    .two_slices(two_slices), .two_chans(two_chans),
    .slice_sel(slice_sel), .chan_sel(chan_sel),
    .slice_hmask(slice_hmask), .chan_hmask(chan_hmask),
    .win_ok(win_ok), .win_lim(win_lim)
  );

  // Non-DRAM detection and closing of the hole below 4 GB.
  always_comb begin
    is_err = in_addr[ADDR_W-1] || ((in_addr >= cfg_tolm) && (in_addr < FOUR_G))
             || (in_addr >= cfg_tohm);
    contig = (in_addr < FOUR_G) ? in_addr : in_addr - (FOUR_G - cfg_tolm);
    win_hit = win_ok && (in_addr >= cfg_win_base) && (in_addr <= win_lim);
  end

  cad_xor_hash #(.W(ADDR_W)) u_slice_hash (
    .addr(in_addr), .mask(slice_hmask), .bit_o(slice_hash));
  cad_xor_hash #(.W(ADDR_W)) u_chan_hash (
    .addr(contig), .mask(chan_hmask), .bit_o(chan_hash));

  // Target selection: window bits override hashes.
  always_comb begin
    win_chan_pos = two_slices ? 6'(WIN_HI_BIT) : 6'(WIN_LO_BIT);
    slice_bit = 1'b0;
    chan_bit  = 1'b0;
    slice_rm  = '{en: two_slices, pos: win_hit ? 6'(WIN_LO_BIT) : slice_sel.pos};
    chan_rm   = '{en: two_chans,  pos: win_hit ? win_chan_pos : chan_sel.pos};
    if (two_slices) slice_bit = win_hit ? in_addr[WIN_LO_BIT] : slice_hash;
    if (two_chans)  chan_bit  = win_hit ? in_addr[win_chan_pos] : chan_hash;
  end

  // Channel bit out first, then the slice bit.
  cad_squeeze #(.W(ADDR_W)) u_sq_chan (.din(contig), .sel(chan_rm), .dout(sq_chan));
  cad_squeeze #(.W(ADDR_W)) u_sq_slice (.din(sq_chan), .sel(slice_rm), .dout(sq_both));

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_target <= '0;
      out_addr   <= '0;
      out_err    <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid  <= 1'b1;
      out_err    <= is_err;
      out_target <= is_err ? 2'b00 : {slice_bit, chan_bit};
      out_addr   <= is_err ? '0 : sq_both;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R10: an accepted address shows up as a result on the next cycle.
  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  // R10: a stalled result stays put.
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_target)
                                   && $stable(out_err)));
  // R1: errored results carry no target or address.
  p_err_clean_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_target == 2'b00 && out_addr == '0));
  // R3: an inactive slice dimension never picks slice 1.
  p_no_slice_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !two_slices) |-> !out_target[1]);
  // R3: an inactive channel dimension never picks channel 1.
  p_no_chan_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !two_chans) |-> !out_target[0]);
endmodule

// File: tb/test_chan_addr_decoder.sv
module test_chan_addr_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] cfg_tolm = 40'h00_8000_0000, cfg_tohm = 40'h02_0000_0000;
  logic        cfg_slice0_off = 0, cfg_slice1_off = 0, cfg_ch1_off = 0, cfg_dual_data = 0;
  logic [1:0]  cfg_s0_chmask = 2'b01, cfg_s1_chmask = 2'b00, cfg_ilv_mode = 0;
  logic        cfg_coarse = 0;
  logic [25:0] cfg_slice_hfield = '0, cfg_chan_hfield = '0;
  logic        cfg_win_en = 0;
  logic [39:0] cfg_win_base = '0, cfg_win_mask = '0;
  logic        in_valid = 0, out_ready = 1;
  logic [39:0] in_addr = '0;
  logic        in_ready, out_valid, out_err;
  logic [1:0]  out_target;
  logic [39:0] out_addr;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [1:0]  got_t;
  logic [39:0] got_a;
  logic        got_e, got_v;

  always #5 clk = ~clk;

  chan_addr_decoder i_chan_addr_decoder (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] squeeze(input logic [39:0] x, input int p);
    logic [39:0] keep;
    if (p < 0) return x;
    keep = (40'd1 << p) - 40'd1;
    return ((x >> 1) & ~keep) | (x & keep);
  endfunction

  // Behavioural model written from the requirements.
  task automatic model(input logic [39:0] a, output logic [1:0] t,
                       output logic [39:0] o, output logic e);
    bit ts, tc, hit, wv;
    int base, ss, cs, srm, crm, mb;
    logic [39:0] shm, chm, c, low, lim;
    ts = !cfg_slice0_off && !cfg_slice1_off && cfg_s0_chmask != 0 && cfg_s1_chmask != 0;
    tc = !cfg_ch1_off && !cfg_dual_data && (cfg_s0_chmask == 3 || cfg_s1_chmask == 3);
    base = (cfg_ilv_mode == 0) ? 10 : (cfg_ilv_mode == 1) ? 11 : 12;
    ss = -1; cs = -1;
    if (ts && tc) begin ss = cfg_coarse ? 29 : base; cs = cfg_coarse ? 30 : base + 1; end
    else if (ts) ss = cfg_coarse ? 29 : base;
    else if (tc) cs = cfg_coarse ? 29 : base;
    shm = 0; chm = 0;
    if (ts) begin
      if (!cfg_coarse) shm = 40'(cfg_slice_hfield) << 6;
      if (!tc) shm[ss] = 1'b1;
    end
    if (tc) begin
      if (!cfg_coarse) chm = 40'(cfg_chan_hfield) << 6;
      if (!ts) chm[cs] = 1'b1;
    end
    low = cfg_win_mask & (~cfg_win_mask + 40'd1);
    wv = cfg_win_en && cfg_win_mask != 0 && cfg_win_mask == ~(low - 40'd1)
         && (cfg_win_base & ~cfg_win_mask) == 0;
    lim = cfg_win_base | ~cfg_win_mask;
    hit = wv && a >= cfg_win_base && a <= lim;
    e = a[39] || (a >= cfg_tolm && a < 40'h1_0000_0000) || a >= cfg_tohm;
    c = (a < 40'h1_0000_0000) ? a : a - (40'h1_0000_0000 - cfg_tolm);
    t = 0; srm = -1; crm = -1;
    if (ts) begin
      if (hit) begin t[1] = a[12]; srm = 12; end
      else begin t[1] = ^(a & shm); srm = ss; end
    end
    if (tc) begin
      mb = ts ? 13 : 12;
      if (hit) begin t[0] = a[mb]; crm = mb; end
      else begin t[0] = ^(c & chm); crm = cs; end
    end
    o = squeeze(squeeze(c, crm), srm);
    if (e) begin t = 0; o = 0; end
  endtask

  task automatic send(input logic [39:0] a);
    @(negedge clk);
    in_addr = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got_v = out_valid; got_t = out_target; got_a = out_addr; got_e = out_err;
    @(negedge clk);
  endtask

  task automatic expect_lit(input string req, input logic [39:0] a,
                            input logic [1:0] t, input logic [39:0] o, input logic e);
    send(a);
    check({req, " valid"}, 64'(got_v), 64'(1'b1));
    check({req, " err"}, 64'(got_e), 64'(e));
    check({req, " target"}, 64'(got_t), 64'(t));
    check({req, " addr"}, 64'(got_a), 64'(o));
  endtask

  task automatic expect_model(input string req, input logic [39:0] a);
    logic [1:0] t; logic [39:0] o; logic e;
    model(a, t, o, e);
    send(a);
    check({req, " err"}, 64'(got_e), 64'(e));
    check({req, " target"}, 64'(got_t), 64'(t));
    check({req, " addr"}, 64'(got_a), 64'(o));
  endtask

  function automatic logic [39:0] rnd_addr();
    return {$urandom, $urandom} & 40'h07_FFFF_FFFF;
  endfunction

  task automatic t_reset();
    check("R10 reset out_valid", 64'(out_valid), 64'(1'b0));
    check("R10 reset in_ready", 64'(in_ready), 64'(1'b1));
  endtask

  task automatic t_errors_contig();
    cfg_s0_chmask = 2'b01; cfg_s1_chmask = 2'b00;
    expect_lit("R1 hole", 40'h00_9000_0000, 2'b00, 40'h0, 1'b1);
    expect_lit("R1 above tohm", 40'h02_0000_0000, 2'b00, 40'h0, 1'b1);
    expect_lit("R1 bit39", 40'h80_0000_0000, 2'b00, 40'h0, 1'b1);
    expect_lit("R2 below tolm", 40'h00_7FFF_FFFF, 2'b00, 40'h00_7FFF_FFFF, 1'b0);
    expect_lit("R2 at 4G", 40'h01_0000_0000, 2'b00, 40'h00_8000_0000, 1'b0);
    expect_lit("R2 low", 40'h00_0000_1234, 2'b00, 40'h00_0000_1234, 1'b0);
  endtask

  task automatic t_selectors();
    cfg_s0_chmask = 2'b01; cfg_s1_chmask = 2'b01;
    expect_lit("R4 mode0 slice bit10", 40'h400, 2'b10, 40'h0, 1'b0);
    expect_lit("R9 shift down", 40'hC00, 2'b10, 40'h400, 1'b0);
    cfg_dual_data = 1'b1; cfg_s0_chmask = 2'b11;
    expect_lit("R3 dual data blocks chan", 40'h800, 2'b00, 40'h400, 1'b0);
    cfg_dual_data = 1'b0;
    for (int m = 0; m < 4; m++) begin
      cfg_ilv_mode = 2'(m);
      cfg_s1_chmask = 2'b11;
      for (int k = 0; k < 20; k++) expect_model("R4 both dims", rnd_addr());
      cfg_s1_chmask = 2'b00;
      for (int k = 0; k < 20; k++) expect_model("R3 chan only", rnd_addr());
      cfg_slice1_off = 1'b1; cfg_s1_chmask = 2'b11;
      for (int k = 0; k < 20; k++) expect_model("R3 slice off", rnd_addr());
      cfg_slice1_off = 1'b0;
    end
    cfg_ilv_mode = 0;
  endtask

  task automatic t_hash();
    cfg_s0_chmask = 2'b11; cfg_s1_chmask = 2'b11;
    cfg_chan_hfield = 26'h1; cfg_slice_hfield = 26'h2;
    expect_lit("R6 chan bit6", 40'h40, 2'b01, 40'h40, 1'b0);
    expect_lit("R6 both", 40'hC0, 2'b11, 40'hC0, 1'b0);
    for (int m = 0; m < 4; m++) begin
      cfg_ilv_mode = 2'(m);
      cfg_chan_hfield = 26'($urandom); cfg_slice_hfield = 26'($urandom);
      for (int k = 0; k < 30; k++) expect_model("R6 random hash", rnd_addr());
    end
    cfg_ilv_mode = 0; cfg_chan_hfield = '0; cfg_slice_hfield = '0;
  endtask

  task automatic t_coarse();
    cfg_coarse = 1'b1; cfg_chan_hfield = '1; cfg_slice_hfield = '1;
    cfg_s0_chmask = 2'b11; cfg_slice1_off = 1'b1;
    expect_lit("R5 chan bit29", 40'h2000_0000, 2'b01, 40'h0, 1'b0);
    expect_lit("R5 field ignored", 40'h6000_0005, 2'b01, 40'h2000_0005, 1'b0);
    cfg_slice1_off = 1'b0; cfg_s1_chmask = 2'b01;
    for (int k = 0; k < 30; k++) expect_model("R5 coarse both", rnd_addr());
    cfg_coarse = 1'b0; cfg_chan_hfield = '0; cfg_slice_hfield = '0;
  endtask

  task automatic t_window();
    cfg_s0_chmask = 2'b11; cfg_s1_chmask = 2'b11;
    cfg_win_en = 1'b1; cfg_win_base = 40'h01_0000_0000; cfg_win_mask = 40'hFF_F000_0000;
    expect_lit("R7 window bits", 40'h01_0000_1000, 2'b10, 40'h00_2000_0000, 1'b0);
    for (int k = 0; k < 30; k++)
      expect_model("R7 window random", 40'h01_0000_0000 | (rnd_addr() & 40'h0F_FFFF));
    cfg_s1_chmask = 2'b00;
    for (int k = 0; k < 20; k++)
      expect_model("R7 window one slice", 40'h01_0000_0000 | (rnd_addr() & 40'h0F_FFFF));
    cfg_s1_chmask = 2'b11; cfg_win_mask = 40'hFF_F000_F000;
    expect_lit("R8 bad mask ignored", 40'h01_0000_1000, 2'b00, 40'h00_2000_0400, 1'b0);
    cfg_win_mask = 40'hFF_F000_0000; cfg_win_base = 40'h01_0000_1000;
    for (int k = 0; k < 10; k++) expect_model("R8 misaligned base", rnd_addr());
    cfg_win_en = 1'b0;
  endtask

  task automatic t_backpressure();
    logic [1:0] t1, t2; logic [39:0] o1, o2; logic e1, e2;
    cfg_s0_chmask = 2'b01; cfg_s1_chmask = 2'b00;
    model(40'h123, t1, o1, e1);
    model(40'h456, t2, o2, e2);
    @(negedge clk);
    out_ready = 1'b0; in_addr = 40'h123; in_valid = 1'b1;
    @(negedge clk);
    in_addr = 40'h456;
    check("R10 stalled in_ready", 64'(in_ready), 64'(1'b0));
    @(negedge clk);
    check("R10 held valid", 64'(out_valid), 64'(1'b1));
    check("R10 held addr", 64'(out_addr), 64'(o1));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second result", 64'(out_addr), 64'(o2));
    @(negedge clk);
    check("R10 drained", 64'(out_valid), 64'(1'b0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_errors_contig();
    t_selectors();
    t_hash();
    t_coarse();
    t_window();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule